// File: doc/BRIEF.md
# Single-Line Bus Borrow Arbiter

This block sits on the processor side of one shared, bidirectional, active-low arbitration line. A second bus master borrows the bus by sending three one-clock pulses over that line. The requester pulses once to ask. The processor pulses once to grant. The requester pulses once more to hand the bus back. The block samples the line on every rising clock edge. It issues the grant only at a point where the processor's own bus cycle may be interrupted. From the grant until the hand-back, it holds a float output high so that the processor's address, data and control drivers stay tristated.

The current bus phase arrives on `bus_phase` as a 3-bit code:
- 0 means idle.
- 1, 2 and 3 mean the first, second and third clocks of a cycle.
- 4 means the last clock of a cycle.
- 5 means an inserted wait clock.
- 6 and 7 are unused and are treated like a mid-cycle clock.

The line is modelled as three signals: the sampled wire (`arb_line_i`), the value the block drives (`arb_line_o`) and that driver's enable (`arb_line_oe`). There is no data stream through the block. All pins are plain level control signals, and there is no valid/ready handshake and no back-pressure.

Top module: `rqgt_arbiter`

## Requirements
- R1: After reset, `arb_line_oe` is 0, `arb_line_o` is 1 and `bus_float` is 0.
- R2: Suppose the processor owns the bus and the line is sampled low at an edge where `bus_phase` is 0 (idle) or 4 (last clock). In the very next clock the block drives a grant: `arb_line_oe`=1 and `arb_line_o`=0. The grant lasts exactly one clock.
- R3: A request sampled while `bus_phase` is 1, 2, 3, 5, 6 or 7 is held pending, and no grant appears. The first later edge that samples `bus_phase` 0 or 4 is followed in the next clock by the grant.
- R4: The block enables its line driver only in the grant clock. In every other clock `arb_line_oe`=0 and `arb_line_o`=1.
- R5: `bus_float` rises in the grant clock. It stays 1 up to and including the clock in which the release pulse (line low) is sampled. It is 0 from the clock after that edge.
- R6: A low line sampled at the first edge after the release edge is ignored. No grant follows and nothing is left pending.
- R7: The line reading low during the grant clock is the block's own pulse. It is not taken as a release, and `bus_float` stays 1 afterwards.
- R8: While the bus is lent, `bus_phase` has no effect. `bus_float` stays 1 and no grant is driven, even when the phase is 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on rising edges |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_phase | input | 3 | Current bus phase code of the processor (see above) |
| arb_line_i | input | 1 | Sampled level of the shared arbitration wire |
| arb_line_o | output | 1 | Level the block drives onto the wire (low = grant) |
| arb_line_oe | output | 1 | Driver enable for the wire, high only in the grant clock |
| bus_float | output | 1 | High while the bus is lent; tristates the processor bus drivers |

## Verification
The grant clock is also the clock in which the shared wire reads low, because the wire carries the block's own pulse. That echo could be mistaken for an early release. Every trial in the bench therefore holds `arb_line_i` low through the grant clock. It then checks that `bus_float` is still high in the clock that follows. A second coincidence is also tested. A fresh request is placed on the edge right after the release, where it overlaps the bus being reclaimed. The bench confirms that no grant appears in the next two clocks.

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;
  localparam int PHASE_W = 3;

  localparam logic [PHASE_W-1:0] PH_IDLE = 3'd0;
  localparam logic [PHASE_W-1:0] PH_LAST = 3'd4;

  typedef enum logic [2:0] {
    ST_OWN   = 3'd0,
    ST_PEND  = 3'd1,
    ST_GRANT = 3'd2,
    ST_LENT  = 3'd3,
    ST_RECL  = 3'd4
  } arb_state_t;
endpackage

// File: rtl/rqgt_boundary.sv
module rqgt_boundary
  import rqgt_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic [PW-1:0] bus_phase,
  output logic          may_grant
);
  always_comb begin
    may_grant = (bus_phase == PW'(PH_IDLE)) || (bus_phase == PW'(PH_LAST));
  end
endmodule

// File: rtl/rqgt_fsm.sv
module rqgt_fsm
  import rqgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_low,
  input  logic       may_grant,
  output arb_state_t state
);
  arb_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OWN:   if (line_low) nxt = may_grant ? ST_GRANT : ST_PEND;
      ST_PEND:  if (may_grant) nxt = ST_GRANT;
      ST_GRANT: nxt = ST_LENT;
      ST_LENT:  if (line_low) nxt = ST_RECL;
      ST_RECL:  nxt = ST_OWN;
      default:  nxt = ST_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OWN;
    else        state <= nxt;
  end

  // R2: grant occupies exactly one clock, then the bus is lent
  assert_grant_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GRANT |=> state == ST_LENT);

  // R3: a pending request survives every non-boundary phase
  assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND && !may_grant) |=> state == ST_PEND);

  // R6: reclaim clock always returns to ownership, ignoring the line
  assert_recl_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RECL |=> state == ST_OWN);

  // R8: lent bus only ends through a sampled release
  assert_lent_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LENT && !line_low) |=> state == ST_LENT);
endmodule

// File: rtl/rqgt_line_drv.sv
module rqgt_line_drv
  import rqgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  arb_state_t state,
  input  logic       line_in,
  output logic       line_o,
  output logic       line_oe,
  output logic       float_o
);
  always_comb begin
    line_oe = (state == ST_GRANT);
    line_o  = !line_oe;
    float_o = (state == ST_GRANT) || (state == ST_LENT);
  end

  // R4: the driver is never enabled two clocks in a row
  assert_drive_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |=> !line_oe);

  // R5: float begins together with the grant pulse
  assert_float_starts_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(float_o) |-> line_oe);

  // R5: float ends only after a low line was sampled
  assert_float_ends_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(float_o) |-> !$past(line_in));
endmodule

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter
  import rqgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] bus_phase,
  input  logic               arb_line_i,
  output logic               arb_line_o,
  output logic               arb_line_oe,
  output logic               bus_float
);
  logic       may_grant;
  arb_state_t state;

  rqgt_boundary #(.PW(PHASE_W)) u_boundary (
    .bus_phase (bus_phase),
    .may_grant (may_grant)
  );

  rqgt_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_low  (!arb_line_i),
    .may_grant (may_grant),
    .state     (state)
  );

  rqgt_line_drv u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .line_in (arb_line_i),
    .line_o  (arb_line_o),
    .line_oe (arb_line_oe),
    .float_o (bus_float)
  );

  // R1: nothing driven or floated in the clock after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!arb_line_oe && !bus_float));
endmodule

// File: tb/rqgt_arbiter_tb.sv
module rqgt_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_phase = 3'd0;
  logic       arb_line_i = 1'b1;
  logic       arb_line_o, arb_line_oe, bus_float;
  int         n_run = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  rqgt_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase),
    .arb_line_i(arb_line_i), .arb_line_o(arb_line_o),
    .arb_line_oe(arb_line_oe), .bus_float(bus_float)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, cycles %0d expected < 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic oe, input logic lo, input logic fl);
    n_run++;
    if (arb_line_oe !== oe || arb_line_o !== lo || bus_float !== fl) begin
      n_fail++;
      $display("FAIL %s: oe/out/float = %b%b%b expected %b%b%b", req,
               arb_line_oe, arb_line_o, bus_float, oe, lo, fl);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit boundary(input int ph);
    return (ph == 0) || (ph == 4);
  endfunction

  initial begin
    @(negedge clk); step();
    chk("R1 reset", 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset", 1'b0, 1'b1, 1'b0);

    for (int ph = 0; ph < 8; ph++) begin
      for (int nw = 0; nw < 4; nw++) begin
        // request pulse at phase ph
        bus_phase  = 3'(ph);
        arb_line_i = 1'b0;
        step();
        arb_line_i = 1'b1;
        if (!boundary(ph)) begin
          chk("R3 pending, no grant", 1'b0, 1'b1, 1'b0);
          for (int k = 0; k < nw; k++) begin
            bus_phase = (k % 2 == 0) ? 3'd5 : 3'(1 + (k % 3));
            step();
            chk("R3 still pending", 1'b0, 1'b1, 1'b0);
          end
          bus_phase = (nw % 2 == 0) ? 3'd4 : 3'd0;
          step();
        end
        // grant clock; wire echoes own low pulse
        chk(boundary(ph) ? "R2 grant next clock" : "R3 grant after boundary",
            1'b1, 1'b0, 1'b1);
        arb_line_i = 1'b0;
        bus_phase  = 3'd4;
        step();
        arb_line_i = 1'b1;
        chk("R7 echo not a release", 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < nw; k++) begin
          bus_phase = 3'(k == 0 ? 4 : 0);
          step();
          chk("R8 lent ignores phase", 1'b0, 1'b1, 1'b1);
        end
        // release pulse
        arb_line_i = 1'b0;
        step();
        chk("R5 float drops after release", 1'b0, 1'b1, 1'b0);
        bus_phase = 3'd0;
        // request right after release (still low) must be ignored
        step();
        arb_line_i = 1'b1;
        chk("R6 no grant after release", 1'b0, 1'b1, 1'b0);
        step();
        chk("R6 nothing pending", 1'b0, 1'b1, 1'b0);
        step();
        chk("R4 line idle", 1'b0, 1'b1, 1'b0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule